// File: doc/BRIEF.md
# PCI Target Burst Address Sequencer

This block sits inside the target side of a PCI interface. It captures the address presented during the address phase and reads the two lowest address bits as a burst-order code. From then on it supplies the 32-bit word address of every data phase. When the burst has to end early, it raises a disconnect request that the target's termination logic turns into a STOP.

Three orderings are supported. The first is a plain linear increment. The second is a read-only cache-line wrap: it starts at the 64-bit beat that holds the requested word, wraps at the line boundary, and asks for a disconnect once one whole line has moved. The third is a reserved ordering that asks for a disconnect after the first data phase. The burst-order code is honoured only for memory commands. Every other command walks linearly and never asks for a disconnect.

Top module: `pci_burst_seq`

## Requirements
- R1: While reset is high, and afterwards until the first address strobe, `word_addr` is 0, `line_wrap` is 0 and `disc_req` is 0.
- R2: In a linear or reserved-order transaction, the cycle after `addr_vld` shows `word_addr` = AD[31:2] of the captured address.
- R3: With code AD[1:0] = 00, each `phase_done` raises `word_addr` by one in the following cycle, rolling over from all ones to zero.
- R4: A read (`is_read` = 1) carrying a memory command and code 10 loads `word_addr` = {AD[31:3], 0} and sets `line_wrap` to 1. Each completed phase then raises only the word index within the line (LINE_BYTES/4 words, 8 by default), wrapping to index 0.
- R5: In cache-line-wrap mode, `disc_req` stays 0 through the first LINE_BYTES/4 − 1 completed phases and becomes 1 in the cycle after the phase that finishes the line.
- R6: A write (`is_read` = 0) with code 10 is treated as a linear burst: `line_wrap` = 0, the address crosses line boundaries, and no disconnect is requested.
- R7: For a memory command with AD[0] = 1 (codes 01 and 11), `disc_req` becomes 1 in the cycle after the first completed phase.
- R8: Memory commands are C/BE = 0110, 0111, 1100, 1110 and 1111. For any other command, the code bits are ignored: `line_wrap` = 0, the burst is linear, and no disconnect is requested.
- R9: `disc_req` stays high until the next `addr_vld`, and is 0 in the cycle after that strobe. While it is high, `phase_done` leaves `word_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld | input | 1 | Address-phase strobe, one cycle |
| ad_in | input | 32 | Address/data lines, sampled with `addr_vld` |
| cbe_in | input | 4 | Command nibble, sampled with `addr_vld` |
| is_read | input | 1 | 1 for a read transaction, sampled with `addr_vld` |
| phase_done | input | 1 | A data phase completed this cycle |
| word_addr | output | 30 | Word address of the current data phase |
| line_wrap | output | 1 | Current burst uses cache-line-wrap order |
| disc_req | output | 1 | Disconnect request, held until the next address phase |

## Verification
The bench builds the block with its default values: a 32-bit address and a 32-byte line. That gives an 8-word wrap window, so a full line completes in eight phases. Starting addresses in the middle of the line exercise the wrap back to index 0 and the disconnect on the eighth phase. Starting near the top of the address space shows the 30-bit rollover of the linear mode.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [1:0] {
        BM_LINEAR = 2'd0,
        BM_WRAP   = 2'd1,
        BM_STOP1  = 2'd2
    } burst_mode_e;

    localparam logic [3:0] CMD_MEM_RD     = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
    localparam logic [3:0] CMD_MEM_RD_MUL = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LN  = 4'b1110;
    localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

    function automatic logic is_mem_cmd(input logic [3:0] cmd);
        logic hit;
        case (cmd)
            CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RD_MUL,
            CMD_MEM_RD_LN, CMD_MEM_WR_INV: hit = 1'b1;
            default:                       hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic burst_mode_e order_to_mode(input logic [1:0] code,
                                                   input logic       mem,
                                                   input logic       rd);
        burst_mode_e m;
        if (!mem)              m = BM_LINEAR;
        else if (code[0])      m = BM_STOP1;
        else if (code[1] && rd) m = BM_WRAP;
        else                   m = BM_LINEAR;
        return m;
    endfunction

endpackage

// File: rtl/pbs_decode.sv
module pbs_decode
    import pbs_pkg::*;
(
    input  logic [1:0]  order_code,
    input  logic [3:0]  cmd,
    input  logic        rd,
    output burst_mode_e mode
);
    logic mem;

    always_comb begin
        mem  = is_mem_cmd(cmd);
        mode = order_to_mode(order_code, mem, rd);
    end

    // R8
    nonmem_linear_chk: assert final (mem || mode == BM_LINEAR);
endmodule

// File: rtl/pbs_addr_gen.sv
module pbs_addr_gen #(
    parameter int WA_W  = 30,
    parameter int IDX_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [WA_W-1:0] load_addr,
    input  logic            load_wrap,
    input  logic            step,
    output logic [WA_W-1:0] word_addr,
    output logic            wrap_mode
);
    logic [WA_W-1:0] addr_q;
    logic [WA_W-1:0] addr_nxt;
    logic [WA_W-1:0] start_addr;
    logic            wrap_q;

    // the critical 64-bit beat: clear the word-in-beat bit when wrapping
    always_comb begin
        start_addr = load_addr;
        if (load_wrap) start_addr[0] = 1'b0;
    end

    generate
        if (IDX_W < WA_W) begin : g_split
            logic [IDX_W-1:0] idx_inc;
            always_comb begin
                idx_inc = addr_q[IDX_W-1:0] + 1'b1;
                if (wrap_q) addr_nxt = {addr_q[WA_W-1:IDX_W], idx_inc};
                else        addr_nxt = addr_q + 1'b1;
            end
        end else begin : g_flat
            always_comb addr_nxt = addr_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            wrap_q <= 1'b0;
        end else if (load) begin
            addr_q <= start_addr;
            wrap_q <= load_wrap;
        end else if (step) begin
            addr_q <= addr_nxt;
        end
    end

    assign word_addr = addr_q;
    assign wrap_mode = wrap_q;

    // R2
    load_linear_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !load_wrap) |=> (word_addr == $past(load_addr)));

    // R4
    wrap_start_chk: assert property (@(posedge clk) disable iff (rst)
        (load && load_wrap) |=> (word_addr[0] == 1'b0 && wrap_mode));

    // R4
    wrap_in_line_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_q && step && !load) |=>
            (word_addr[WA_W-1:IDX_W] == $past(word_addr[WA_W-1:IDX_W])));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!wrap_q && step && !load) |=> (word_addr == $past(word_addr) + 1'b1));
endmodule

// File: rtl/pbs_term.sv
module pbs_term
    import pbs_pkg::*;
#(
    parameter int LINE_WORDS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  burst_mode_e start_mode,
    input  logic        phase_done,
    output logic        disc_req
);
    localparam int CNT_W = $clog2(LINE_WORDS) + 1;
    localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(LINE_WORDS - 1);

    burst_mode_e      mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             disc_q;
    logic             accept;

    assign accept = phase_done && !disc_q && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= BM_LINEAR;
            cnt_q  <= '0;
            disc_q <= 1'b0;
        end else if (start) begin
            mode_q <= start_mode;
            cnt_q  <= '0;
            disc_q <= 1'b0;
        end else if (accept) begin
            case (mode_q)
                BM_STOP1: disc_q <= 1'b1;
                BM_WRAP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_PHASE) disc_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign disc_req = disc_q;

    // R9
    clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !disc_req);

    // R9
    hold_disc_chk: assert property (@(posedge clk) disable iff (rst)
        (disc_req && !start) |=> disc_req);

    // R7
    stop_first_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == BM_STOP1 && accept) |=> disc_req);

    // R6
    linear_never_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == BM_LINEAR && !disc_req && !start) |=> !disc_req);
endmodule

// File: rtl/pci_burst_seq.sv
module pci_burst_seq
    import pbs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] ad_in,
    input  logic [3:0]        cbe_in,
    input  logic              is_read,
    input  logic              phase_done,
    output logic [ADDR_W-3:0] word_addr,
    output logic              line_wrap,
    output logic              disc_req
);
    localparam int WA_W       = ADDR_W - 2;
    localparam int LINE_WORDS = LINE_BYTES / 4;
    localparam int IDX_W      = $clog2(LINE_WORDS);

    burst_mode_e mode_dec;
    logic        step;

    pbs_decode u_decode (
        .order_code (ad_in[1:0]),
        .cmd        (cbe_in),
        .rd         (is_read),
        .mode       (mode_dec)
    );

    assign step = phase_done && !disc_req && !addr_vld;

    pbs_addr_gen #(
        .WA_W  (WA_W),
        .IDX_W (IDX_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (addr_vld),
        .load_addr (ad_in[ADDR_W-1:2]),
        .load_wrap (mode_dec == BM_WRAP),
        .step      (step),
        .word_addr (word_addr),
        .wrap_mode (line_wrap)
    );

    pbs_term #(
        .LINE_WORDS (LINE_WORDS)
    ) u_term (
        .clk        (clk),
        .rst        (rst),
        .start      (addr_vld),
        .start_mode (mode_dec),
        .phase_done (phase_done),
        .disc_req   (disc_req)
    );

    // R9
    frozen_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (disc_req && !addr_vld) |=> $stable(word_addr));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (word_addr == '0 && !line_wrap && !disc_req));
endmodule

// File: tb/tb_pci_burst_seq.sv
module tb_pci_burst_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_vld = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_in = '0;
    logic        is_read = 1'b0;
    logic        phase_done = 1'b0;
    logic [29:0] word_addr;
    logic        line_wrap;
    logic        disc_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pci_burst_seq dut (
        .clk        (clk),
        .rst        (rst),
        .addr_vld   (addr_vld),
        .ad_in      (ad_in),
        .cbe_in     (cbe_in),
        .is_read    (is_read),
        .phase_done (phase_done),
        .word_addr  (word_addr),
        .line_wrap  (line_wrap),
        .disc_req   (disc_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [31:0] ad, input logic [3:0] cmd, input logic rd);
        @(negedge clk);
        addr_vld = 1'b1; ad_in = ad; cbe_in = cmd; is_read = rd;
        @(negedge clk);
        addr_vld = 1'b0; ad_in = '0; cbe_in = '0; is_read = 1'b0;
    endtask

    task automatic one_phase();
        @(negedge clk);
        phase_done = 1'b1;
        @(negedge clk);
        phase_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 word_addr", {2'b0, word_addr}, 32'h0);
        check("R1 line_wrap", {31'b0, line_wrap}, 32'h0);
        check("R1 disc_req", {31'b0, disc_req}, 32'h0);
    endtask

    task automatic t_linear();
        addr_phase(32'h0000_1000, 4'b0110, 1'b1);
        check("R2 linear start", {2'b0, word_addr}, 32'h400);
        for (int k = 1; k <= 5; k++) begin
            one_phase();
            check("R3 linear step", {2'b0, word_addr}, 32'h400 + k);
        end
        check("R3 no disconnect", {31'b0, disc_req}, 32'h0);
        addr_phase(32'hFFFF_FFFC, 4'b0110, 1'b1);
        check("R2 top start", {2'b0, word_addr}, 32'h3FFF_FFFF);
        one_phase();
        check("R3 rollover", {2'b0, word_addr}, 32'h0);
    endtask

    task automatic t_wrap(input logic [31:0] ad, input logic [3:0] cmd);
        logic [29:0] base;
        int start_idx;
        base      = ad[31:2] & ~30'h7;
        start_idx = int'(ad[4:3]) * 2;
        addr_phase(ad, cmd, 1'b1);
        check("R4 wrap flag", {31'b0, line_wrap}, 32'h1);
        check("R4 critical beat", {2'b0, word_addr}, {2'b0, base} + start_idx);
        for (int k = 1; k <= 8; k++) begin
            one_phase();
            check("R4 wrap seq", {2'b0, word_addr}, {2'b0, base} + ((start_idx + k) % 8));
            check("R5 disc timing", {31'b0, disc_req}, (k == 8) ? 32'h1 : 32'h0);
        end
        one_phase();
        check("R9 address frozen", {2'b0, word_addr}, {2'b0, base} + start_idx);
        check("R9 disc held", {31'b0, disc_req}, 32'h1);
    endtask

    task automatic t_write_code10();
        addr_phase(32'h0000_2016, 4'b0111, 1'b0);
        check("R6 no wrap flag", {31'b0, line_wrap}, 32'h0);
        check("R6 start", {2'b0, word_addr}, 32'h805);
        check("R9 cleared by strobe", {31'b0, disc_req}, 32'h0);
        for (int k = 1; k <= 8; k++) one_phase();
        check("R6 crosses line", {2'b0, word_addr}, 32'h80D);
        check("R6 no disconnect", {31'b0, disc_req}, 32'h0);
    endtask

    task automatic t_reserved();
        addr_phase(32'h0000_3001, 4'b1100, 1'b1);
        check("R2 reserved start", {2'b0, word_addr}, 32'hC00);
        check("R7 idle before phase", {31'b0, disc_req}, 32'h0);
        one_phase();
        check("R7 disc after first", {31'b0, disc_req}, 32'h1);
        check("R7 addr advanced once", {2'b0, word_addr}, 32'hC01);
        one_phase();
        check("R9 frozen after stop", {2'b0, word_addr}, 32'hC01);
        addr_phase(32'h0000_4003, 4'b1111, 1'b0);
        check("R9 cleared", {31'b0, disc_req}, 32'h0);
        check("R2 code11 start", {2'b0, word_addr}, 32'h1000);
        one_phase();
        check("R7 code11 disc", {31'b0, disc_req}, 32'h1);
    endtask

    task automatic t_nonmem();
        addr_phase(32'h0000_5003, 4'b0010, 1'b1);
        check("R8 start", {2'b0, word_addr}, 32'h1400);
        check("R8 disc cleared", {31'b0, disc_req}, 32'h0);
        for (int k = 1; k <= 3; k++) one_phase();
        check("R8 linear", {2'b0, word_addr}, 32'h1403);
        check("R8 no disconnect", {31'b0, disc_req}, 32'h0);
        addr_phase(32'h0000_5016, 4'b0010, 1'b1);
        check("R8 code10 no wrap", {31'b0, line_wrap}, 32'h0);
        check("R8 code10 start", {2'b0, word_addr}, 32'h1405);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_linear();
        t_wrap(32'h0000_2016, 4'b0110);
        t_write_code10();
        t_wrap(32'h0000_601A, 4'b1110);
        t_reserved();
        t_nonmem();
        t_wrap(32'h0000_7002, 4'b1100);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule